// File: doc/BRIEF.md
# Late-Select Microcode Sequencer

This block picks the next microinstruction of a microprogrammed control unit. It does so without spending an extra cycle on a conditional micro-branch. Each access to the control store fetches a whole aligned group of eight successor words into a candidate register. In the following cycle, the condition bits from the ALU choose one of four words from that group. They arrive late and feed only the final multiplexer. The current microinstruction names the next group, and one bit of it picks which half of the group is eligible. A two-bit select mode in the same word tells the multiplexer which condition inputs form the 1-of-4 index.

A new macroinstruction enters through a dispatch port. The decoder presents a full micro-address, and the word at that address appears one cycle later, whatever the conditions are. A stall input freezes the sequencer. While stalled, the outputs show the last committed selection. A separate scan engine reads the whole store serially through its own read port and folds every word into a 16-bit checksum. It does this while sequencing continues.

The sequencer control has three states. SQ_IDLE is the state before any dispatch. SQ_DISP is the cycle that shows a dispatched word. SQ_RUN covers condition-driven sequencing. The transitions are as follows:
- idle to disp on an accepted dispatch.
- disp or run to disp on an accepted dispatch.
- disp to run, and run to run, on any other unstalled cycle.
- any state to itself while stalled.

The scan engine has four states: SC_IDLE, SC_FILL, SC_ACC and SC_DONE. The transitions are:
- any state to fill on a start.
- fill to acc.
- acc to acc until the last word has been folded, then acc to done.

Top module: `useq_top`

## Requirements
- R1: While reset is held, uinst_valid, uinst, uaddr, scan_done and scan_sum are all zero.
- R2: The store word at address a is the low WORD_W bits of v ^ (v >> 16), where v = (a * 0x9E3779B1 + 0x5A5A1234) mod 2^32. Word bits [1:0] are the select mode, bit [2] is the set bit and bits [5:3] are the next group number (default parameters).
- R3: If a dispatch is accepted (dispatch_valid high, stall low) at an edge, then in the next unstalled cycle uaddr equals that dispatch address, uinst equals its store word and uinst_valid is high, whatever cond is.
- R4: In each unstalled cycle after a non-dispatch unstalled cycle out of idle, uaddr is {next group of the previous uinst, set bit of the previous uinst, two-bit pair}. The pair comes from the current-cycle cond, and uinst is the store word at uaddr.
- R5: The select mode forms the pair as follows: 0 gives {cond[1],cond[0]}, 1 gives {cond[3],cond[2]}, 2 gives {0,cond[0]} and 3 gives 00.
- R6: A dispatch accepted while sequencing overrides the successor that the current word and condition would have chosen.
- R7: While stall is high, nothing advances and dispatch is ignored. uinst and uaddr show the last selection committed at an unstalled edge, and uinst_valid is high only if one exists.
- R8: After scan_start is sampled at an edge, scan_done rises exactly DEPTH+1 edges later. scan_sum then equals the fold over addresses 0..DEPTH-1 of s = rotl1(s) ^ word, starting from s = 0, with the word split into 16-bit chunks that are XORed together.
- R9: scan_done and scan_sum hold until the next scan_start. A start in any state restarts the scan, and scanning does not disturb sequencing.
- R10: Before the first dispatch, uinst_valid stays low and uinst and uaddr stay zero whatever cond is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dispatch_valid | input | 1 | Decode presents a new entry address |
| dispatch_addr | input | ADDR_W | Entry micro-address from decode |
| cond | input | 4 | Late ALU condition bits |
| stall | input | 1 | Freeze sequencing |
| scan_start | input | 1 | Begin or restart a store checksum scan |
| uinst_valid | output | 1 | uinst holds a microinstruction |
| uinst | output | WORD_W | Selected microinstruction |
| uaddr | output | ADDR_W | Address of the selected microinstruction |
| scan_done | output | 1 | Checksum complete |
| scan_sum | output | 16 | Running or final checksum |

## Verification
The hardest case to reach is a stall that begins in the very cycle after a dispatch was accepted. The design then shows the last committed word from the previous stream rather than the entry word. When the stall ends, the dispatched word must still appear. A random mix of frequent stalls and dispatches produces this case many times, and directed steps cover dispatches at store boundaries, back-to-back dispatches, and stall with dispatch while idle. Scan starts, including a restart mid-scan, are dropped into the running random traffic so that the checksum is taken while the sequencer is moving.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int GROUP   = 8;
    localparam int MAXW    = 512;
    localparam int SUM_W   = 16;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_DISP = 2'd1,
        SQ_RUN  = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_FILL = 2'd1,
        SC_ACC  = 2'd2,
        SC_DONE = 2'd3
    } scan_state_e;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_TWO  = 2'd2,
        SEL_FALL = 2'd3
    } sel_mode_e;

    function automatic logic [31:0] mix32(input logic [31:0] x);
        logic [31:0] v;
        v = x * 32'h9E37_79B1 + 32'h5A5A_1234;
        return v ^ (v >> 16);
    endfunction

    // Store contents, computed; wider words use further 32-bit chunks.
    function automatic logic [MAXW-1:0] rom_word(input int unsigned a);
        logic [MAXW-1:0] r;
        r = '0;
        for (int j = 0; j < MAXW / 32; j++) begin
            r[32*j +: 32] = mix32(32'(a) + (32'(j) << 16));
        end
        return r;
    endfunction

    function automatic logic [SUM_W-1:0] rotl1(input logic [SUM_W-1:0] s);
        return {s[SUM_W-2:0], s[SUM_W-1]};
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter int  WORD_W = 16,
    parameter int  DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int GRP_W  = ADDR_W - 3
) (
    input  logic                      clk,
    input  logic                      grp_en,
    input  logic [GRP_W-1:0]          grp_addr,
    output logic [GROUP*WORD_W-1:0]   grp_words,
    input  logic [ADDR_W-1:0]         scan_addr,
    output logic [WORD_W-1:0]         scan_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_word
        localparam logic [MAXW-1:0] FULL = rom_word(a);
        assign mem[a] = FULL[WORD_W-1:0];
    end

    // Group port: all eight words of the aligned group in one access.
    always_ff @(posedge clk) begin
        if (grp_en) begin
            for (int k = 0; k < GROUP; k++) begin
                grp_words[k*WORD_W +: WORD_W] <= mem[{grp_addr, 3'(k)}];
            end
        end
    end

    // Serial port for the checksum scan.
    always_ff @(posedge clk) begin
        scan_word <= mem[scan_addr];
    end

endmodule

// File: rtl/useq_select.sv
module useq_select
    import useq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [GROUP*WORD_W-1:0] cand,
    input  logic                    dispatched,
    input  logic [2:0]              disp_off,
    input  logic [1:0]              mode,
    input  logic                    set_bit,
    input  logic [3:0]              cond,
    output logic [2:0]              idx,
    output logic [WORD_W-1:0]       word
);

    logic [WORD_W-1:0] cw [GROUP];
    logic [1:0]        pair;

    for (genvar k = 0; k < GROUP; k++) begin : g_split
        assign cw[k] = cand[k*WORD_W +: WORD_W];
    end

    // Late path: cond feeds only this small mux.
    always_comb begin
        unique case (sel_mode_e'(mode))
            SEL_LOW:  pair = cond[1:0];
            SEL_HIGH: pair = cond[3:2];
            SEL_TWO:  pair = {1'b0, cond[0]};
            SEL_FALL: pair = 2'b00;
        endcase
        idx = dispatched ? disp_off : {set_bit, pair};
    end

    assign word = cw[idx];

endmodule

// File: rtl/useq_scan.sv
module useq_scan
    import useq_pkg::*;
#(
    parameter int  WORD_W = 16,
    parameter int  DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic              done,
    output logic [SUM_W-1:0]  sum
);

    localparam int NCH   = (WORD_W + SUM_W - 1) / SUM_W;
    localparam int CNT_W = ADDR_W + 1;

    scan_state_e        st_q, st_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [SUM_W-1:0]   sum_q;
    logic [NCH*SUM_W-1:0] padded;
    logic [SUM_W-1:0]   fold;
    logic               last;

    assign last = (cnt_q == CNT_W'(DEPTH));

    always_comb begin
        padded = '0;
        padded[WORD_W-1:0] = rd_word;
        fold = '0;
        for (int c = 0; c < NCH; c++) begin
            fold = fold ^ padded[SUM_W*c +: SUM_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SC_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d = SC_FILL;
        end else begin
            unique case (st_q)
                SC_IDLE: st_d = SC_IDLE;
                SC_FILL: st_d = SC_ACC;
                SC_ACC:  st_d = last ? SC_DONE : SC_ACC;
                SC_DONE: st_d = SC_DONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            sum_q <= '0;
        end else begin
            unique case (st_q)
                SC_FILL: cnt_q <= cnt_q + 1'b1;
                SC_ACC: begin
                    sum_q <= rotl1(sum_q) ^ fold;
                    if (!last) cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign rd_addr = cnt_q[ADDR_W-1:0];
    assign done    = (st_q == SC_DONE);
    assign sum     = sum_q;

    // R9: a finished result stays put until the next start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(sum)));

endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int  WORD_W = 16,
    parameter int  DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dispatch_valid,
    input  logic [ADDR_W-1:0] dispatch_addr,
    input  logic [3:0]        cond,
    input  logic              stall,
    input  logic              scan_start,
    output logic              uinst_valid,
    output logic [WORD_W-1:0] uinst,
    output logic [ADDR_W-1:0] uaddr,
    output logic              scan_done,
    output logic [SUM_W-1:0]  scan_sum
);

    localparam int GRP_W = ADDR_W - 3;
    localparam int NXT_LO = 3;

    seq_state_e               st_q, st_d;
    logic [GRP_W-1:0]         grp_q, grp_d;
    logic [1:0]               mode_q;
    logic                     set_q;
    logic [2:0]               off_q;
    logic [WORD_W-1:0]        last_w_q;
    logic [ADDR_W-1:0]        last_a_q;
    logic                     have_q;
    logic                     up_q;

    logic [GROUP*WORD_W-1:0]  cand;
    logic [2:0]               idx;
    logic [WORD_W-1:0]        live_w;
    logic [ADDR_W-1:0]        live_a;
    logic [ADDR_W-1:0]        scan_addr;
    logic [WORD_W-1:0]        scan_word;
    logic                     commit;

    assign grp_d  = dispatch_valid ? dispatch_addr[ADDR_W-1:3]
                                   : live_w[NXT_LO +: GRP_W];
    assign live_a = {grp_q, idx};
    assign commit = !stall && (st_q != SQ_IDLE);

    useq_rom #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rom (
        .clk       (clk),
        .grp_en    (!stall),
        .grp_addr  (grp_d),
        .grp_words (cand),
        .scan_addr (scan_addr),
        .scan_word (scan_word)
    );

    useq_select #(.WORD_W(WORD_W)) u_sel (
        .cand       (cand),
        .dispatched (st_q == SQ_DISP),
        .disp_off   (off_q),
        .mode       (mode_q),
        .set_bit    (set_q),
        .cond       (cond),
        .idx        (idx),
        .word       (live_w)
    );

    useq_scan #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (scan_start),
        .rd_addr (scan_addr),
        .rd_word (scan_word),
        .done    (scan_done),
        .sum     (scan_sum)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (!stall) begin
            if (dispatch_valid) begin
                st_d = SQ_DISP;
            end else begin
                unique case (st_q)
                    SQ_IDLE:         st_d = SQ_IDLE;
                    SQ_DISP, SQ_RUN: st_d = SQ_RUN;
                    default:         st_d = SQ_IDLE;
                endcase
            end
        end
    end

    // Sequencing registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q    <= '0;
            mode_q   <= '0;
            set_q    <= 1'b0;
            off_q    <= '0;
            last_w_q <= '0;
            last_a_q <= '0;
            have_q   <= 1'b0;
            up_q     <= 1'b0;
        end else begin
            up_q <= 1'b1;
            if (commit) begin
                last_w_q <= live_w;
                last_a_q <= live_a;
                have_q   <= 1'b1;
            end
            if (!stall) begin
                if (dispatch_valid) begin
                    grp_q <= grp_d;
                    off_q <= dispatch_addr[2:0];
                end else if (st_q != SQ_IDLE) begin
                    grp_q  <= grp_d;
                    mode_q <= live_w[1:0];
                    set_q  <= live_w[2];
                end
            end
        end
    end

    // Outputs
    always_comb begin
        uinst_valid = 1'b0;
        uinst       = '0;
        uaddr       = '0;
        if (stall) begin
            uinst_valid = have_q;
            uinst       = last_w_q;
            uaddr       = last_a_q;
        end else begin
            unique case (st_q)
                SQ_IDLE: ;
                SQ_DISP, SQ_RUN: begin
                    uinst_valid = 1'b1;
                    uinst       = live_w;
                    uaddr       = live_a;
                end
                default: ;
            endcase
        end
    end

    // R3: an accepted entry address is what appears next
    p_dispatch_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && $past(dispatch_valid && !stall) && !stall)
        |-> (uinst_valid && uaddr == $past(dispatch_addr)));

    // R4: the group comes from the previous word's successor field
    p_group_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !stall && $past(!stall && !dispatch_valid && st_q != SQ_IDLE))
        |-> (uaddr[ADDR_W-1:3] == $past(uinst[NXT_LO +: GRP_W])));

    // R7: outputs frozen across a stall
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && stall && $past(stall))
        |-> ($stable(uinst) && $stable(uaddr) && $stable(uinst_valid)));

endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb;

    localparam int WORD_W = 16;
    localparam int DEPTH  = 64;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dv = 1'b0;
    logic [ADDR_W-1:0] da = '0;
    logic [3:0]        cond = '0;
    logic              stall = 1'b0;
    logic              ss = 1'b0;
    logic              uv;
    logic [WORD_W-1:0] uw;
    logic [ADDR_W-1:0] ua;
    logic              sd;
    logic [15:0]       sum;

    always #4 clk = ~clk;

    useq_top #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .dispatch_valid(dv), .dispatch_addr(da),
        .cond(cond), .stall(stall), .scan_start(ss),
        .uinst_valid(uv), .uinst(uw), .uaddr(ua),
        .scan_done(sd), .scan_sum(sum)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    // reference state
    int          ms = 0;
    logic [2:0]  mg = '0, moff = '0;
    logic [1:0]  mmode = '0;
    logic        mset = 1'b0, mhave = 1'b0, prev_run = 1'b0;
    logic [15:0] mlw = '0;
    logic [5:0]  mla = '0;
    int          sc_cnt = 0;
    bit          sc_busy = 0, sc_done = 0;
    logic [15:0] exp_sum;

    function automatic logic [15:0] romw(int a);
        logic [31:0] v;
        v = 32'(a) * 32'h9E37_79B1 + 32'h5A5A_1234;
        v = v ^ (v >> 16);
        return v[15:0];
    endfunction

    function automatic logic [1:0] pick(logic [1:0] m, logic [3:0] c);
        case (m)
            2'd0:    return c[1:0];
            2'd1:    return c[3:2];
            2'd2:    return {1'b0, c[0]};
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(logic d_v, logic [5:0] d_a, logic [3:0] c, logic s, logic st, string tag_ovr);
        logic [2:0]  idx;
        logic [15:0] lw, ew;
        logic [5:0]  la, ea;
        logic        ev;
        string       t;
        @(negedge clk);
        dv = d_v; da = d_a; cond = c; stall = s; ss = st;
        #2;
        idx = (ms == 1) ? moff : {mset, pick(mmode, c)};
        la  = {mg, idx};
        lw  = romw(int'(la));
        if (s)            begin ev = mhave; ew = mlw; ea = mla; end
        else if (ms == 0) begin ev = 1'b0;  ew = '0;  ea = '0;  end
        else              begin ev = 1'b1;  ew = lw;  ea = la;  end
        if (tag_ovr != "")  t = tag_ovr;
        else if (s)         t = "R7";
        else if (ms == 0)   t = "R10";
        else if (ms == 1)   t = prev_run ? "R6" : "R3";
        else                t = "R4";
        chk(t, "uinst_valid", 32'(uv), 32'(ev));
        chk(t, "uaddr", 32'(ua), 32'(ea));
        chk(t, "uinst", 32'(uw), 32'(ew));
        if (!s && ms == 2) chk("R5", "cond index", 32'(ua[1:0]), 32'(pick(mmode, c)));
        chk(sc_done ? "R9" : "R8", "scan_done", 32'(sd), 32'(sc_done));
        if (sc_done) chk("R8", "scan_sum", 32'(sum), 32'(exp_sum));
        @(posedge clk);
        if (!s) begin
            if (ms != 0) begin mlw = lw; mla = la; mhave = 1'b1; end
            if (d_v) begin
                prev_run = (ms != 0); ms = 1; mg = d_a[5:3]; moff = d_a[2:0];
            end else if (ms != 0) begin
                prev_run = 1'b0; ms = 2; mg = lw[5:3]; mmode = lw[1:0]; mset = lw[2];
            end
        end
        if (st) begin sc_busy = 1; sc_cnt = 0; sc_done = 0; end
        else if (sc_busy) begin
            sc_cnt++;
            if (sc_cnt == DEPTH + 1) begin sc_busy = 0; sc_done = 1; end
        end
    endtask

    task automatic rnd_step(int dv_div, int st_div, int ss_div);
        step(($urandom % dv_div) == 0, 6'($urandom), 4'($urandom),
             ($urandom % st_div) == 0, ($urandom % ss_div) == 0, "");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7193));
        exp_sum = '0;
        for (int a = 0; a < DEPTH; a++) exp_sum = {exp_sum[14:0], exp_sum[15]} ^ romw(a);

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "uinst_valid", 32'(uv), 0);
        chk("R1", "uaddr", 32'(ua), 0);
        chk("R1", "uinst", 32'(uw), 0);
        chk("R1", "scan_done", 32'(sd), 0);
        chk("R1", "scan_sum", 32'(sum), 0);
        rst_n = 1'b1;

        // R10: idle ignores cond
        for (int i = 0; i < 6; i++) step(0, 0, 4'($urandom), 0, 0, "R10");
        // R7: dispatch while stalled and idle is dropped
        step(1, 6'd9, 4'hF, 1, 0, "R7");
        step(0, 0, 4'h5, 0, 0, "R10");
        // R2: store words at the boundaries
        step(1, 6'd0, 4'h3, 0, 0, "");
        step(0, 0, 4'hA, 0, 0, "R2");
        step(1, 6'd63, 4'h0, 0, 0, "");
        step(0, 0, 4'hC, 0, 0, "R2");
        for (int i = 0; i < 8; i++) step(0, 0, 4'($urandom), 0, 0, "");
        // R6: back-to-back and in-flight dispatches
        step(1, 6'd10, 4'h1, 0, 0, "");
        step(1, 6'd37, 4'h2, 0, 0, "");
        step(0, 0, 4'h7, 0, 0, "");
        // stall immediately after an accepted dispatch, then release
        step(1, 6'd21, 4'h4, 0, 0, "");
        for (int i = 0; i < 5; i++) step(1, 6'($urandom), 4'($urandom), 1, 0, "R7");
        step(0, 0, 4'h9, 0, 0, "R3");
        for (int i = 0; i < 10; i++) step(0, 0, 4'($urandom), 0, 0, "");

        // R8/R9: scan during traffic, restart mid-scan
        step(0, 0, 4'($urandom), 0, 1, "");
        for (int i = 0; i < 20; i++) rnd_step(6, 4, 100000);
        step(0, 0, 4'($urandom), 0, 1, "");
        for (int i = 0; i < DEPTH + 20; i++) rnd_step(6, 4, 100000);
        chk("R9", "scan_done after run", 32'(sd), 1);

        // mixed random
        for (int i = 0; i < 4000; i++) rnd_step(8, 5, 500);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule